// File: doc/BRIEF.md
# Three-Lane Window FIFO Buffer

This block feeds a pipelined datapath that consumes a window of three consecutive array elements on every cycle. For iteration `i` it issues three single-element read requests to a memory port, for elements `base + i`, `base + i + 1` and `base + i + 2`. It collects the three in-order responses, then writes them together into three FIFO lanes, one lane per window position. Consecutive windows overlap by two elements, but nothing is reused: every iteration fetches its whole window again. The lane heads are presented side by side as one aligned window.

The block handles rate mismatch in both directions. When the lanes, counted together with the windows still in flight, have no free slot, it stops issuing requests. When no window is ready, one of two behaviours applies, chosen by a parameter. In the first, it raises a stall signal and holds the last accepted window on the data bus; this suits a consumer with feedback in its pipeline. In the second, it passes a bubble: valid is low and the data bus is zero. A done flag rises once the last window of the run has been accepted by the consumer.

The request sequencer is a state machine with these states:
- `FS_IDLE` waits after reset. It moves to `FS_HEAD` on `start`.
- `FS_HEAD` requests the first element of a window, but only while a lane slot is free. When that request is accepted, it moves to `FS_BODY`.
- `FS_BODY` requests the remaining two elements. When the third is accepted, it returns to `FS_HEAD`, or moves to `FS_DRAIN` if that window was the last.
- `FS_DRAIN` waits until the consumer has accepted all windows, then moves to `FS_FINISH`.
- `FS_FINISH` holds `done` high. It moves back to `FS_HEAD` on `start`.

Top module: `wfb_window_buffer`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `mem_req`, `win_valid` and `done` are 0.
- R2: Windows leave in iteration order. Window `i` carries element `base+i` in `win_data[31:0]`, element `base+i+1` in `win_data[63:32]` and element `base+i+2` in `win_data[95:64]`.
- R3: Accepted request addresses follow the order `base+i`, `base+i+1`, `base+i+2` for `i = 0, 1, ...`. Each window begins one element after the previous one.
- R4: A run of N_ITER windows (default 100) makes exactly 3·N_ITER memory accesses (300 by default).
- R5: The number of windows whose first element has been accepted, minus the windows popped, never exceeds LANE_DEPTH (default 4). With the consumer blocked, requests stop after 3·LANE_DEPTH accesses.
- R6: With HOLD_CONSUMER=1, whenever `win_valid` is 0, `win_stall` is 1 and `win_data` equals the last window the consumer accepted (zero before the first one).
- R7: With HOLD_CONSUMER=0, whenever `win_valid` is 0, `win_stall` is 0 and `win_data` is zero. Valid windows and their timing are the same as in mode 1.
- R8: `done` is 0 while any window of the run is still unaccepted. It is 1 within two cycles after the last window is accepted, and stays 1 until the next `start`.
- R9: A `start` pulse while a run is in progress has no effect. Neither the addresses nor the windows of that run change.
- R10: All three lanes always hold the same number of entries. `win_valid` is 1 only when every lane holds at least one entry, and it is 0 once the run is done.
- R11: A request that is not accepted stays asserted, with an unchanged address, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run; sampled only when idle or finished |
| base_addr | input | ADDR_W | Element index of the first element of the run |
| mem_req | output | 1 | Element read request |
| mem_addr | output | ADDR_W | Element index being requested |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read response valid; responses arrive in request order |
| mem_rdata | input | DATA_W | Read response data |
| win_valid | output | 1 | A complete window is presented |
| win_ready | input | 1 | Consumer accepts the presented window |
| win_data | output | 3·DATA_W | Window; position 0 in the low bits |
| win_stall | output | 1 | Hold request to the consumer (mode 1 only) |
| done | output | 1 | All windows of the run have been accepted |

## Verification
The assertions assume that the memory returns exactly one response per accepted request, in order, and never in the same cycle as that request. They also assume that `start` is not pulsed while the run's windows are being streamed, except where R9 deliberately tests it. The bench's memory model meets this with a fixed two-cycle response pipeline. A pseudo-random sequence throttles `mem_ready` and `win_ready`. Two instances, one per stall mode, receive identical stimulus so that their valid windows can be compared cycle by cycle.

// File: rtl/wfb_pkg.sv
package wfb_pkg;

    // Number of elements in one window; one FIFO lane per position.
    localparam int WIN_LEN = 3;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_HEAD,
        FS_BODY,
        FS_DRAIN,
        FS_FINISH
    } fetch_state_t;

endpackage

// File: rtl/wfb_lane.sv
module wfb_lane #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  level
);

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wp_q;
    logic [PTR_W-1:0]  rp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              push_ok;
    logic              pop_ok;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign level   = cnt_q;
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign rdata   = slot_q[rp_q];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            slot_q[wp_q] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) begin
                wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
            if (pop_ok) begin
                rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/wfb_assemble.sv
module wfb_assemble
    import wfb_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(WIN_LEN),
    localparam int WIN_W = WIN_LEN * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rvalid,
    input  logic [DATA_W-1:0] rdata,
    output logic              push,
    output logic [WIN_W-1:0]  window
);

    logic [POS_W-1:0] pos_q;
    logic             last_pos;

    assign last_pos = (pos_q == POS_W'(WIN_LEN - 1));
    assign push     = rvalid & last_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (rvalid) begin
            pos_q <= last_pos ? '0 : pos_q + 1'b1;
        end
    end

    // Earlier positions are staged; the last arriving element goes straight through.
    for (genvar k = 0; k < WIN_LEN - 1; k++) begin : g_stage
        logic [DATA_W-1:0] stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else if (rvalid && pos_q == POS_W'(k)) begin
                stage_q <= rdata;
            end
        end
        assign window[k*DATA_W +: DATA_W] = stage_q;
    end

    assign window[(WIN_LEN-1)*DATA_W +: DATA_W] = rdata;

endmodule

// File: rtl/wfb_fetch.sv
module wfb_fetch
    import wfb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4,
    parameter int N_ITER = 100,
    localparam int CLM_W = $clog2(DEPTH + 1),
    localparam int IT_W  = $clog2(N_ITER + 1),
    localparam int OFF_W = $clog2(WIN_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              mem_ready,
    input  logic              pop,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              done
);

    fetch_state_t      state_q;
    fetch_state_t      state_d;
    logic [ADDR_W-1:0] base_q;
    logic [IT_W-1:0]   iter_q;
    logic [IT_W-1:0]   pops_q;
    logic [OFF_W-1:0]  off_q;
    logic [CLM_W-1:0]  claimed_q;

    logic space;
    logic accept;
    logic launch;
    logic last_off;
    logic last_iter;
    logic head_take;

    assign space     = (claimed_q < CLM_W'(DEPTH));
    assign accept    = mem_req & mem_ready;
    assign launch    = start & ((state_q == FS_IDLE) | (state_q == FS_FINISH));
    assign last_off  = (off_q == OFF_W'(WIN_LEN - 1));
    assign last_iter = (iter_q == IT_W'(N_ITER - 1));
    assign head_take = accept & (state_q == FS_HEAD);
    assign mem_addr  = base_q + ADDR_W'(iter_q) + ADDR_W'(off_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:   if (start) state_d = FS_HEAD;
            FS_HEAD:   if (accept) state_d = FS_BODY;
            FS_BODY:   if (accept && last_off) state_d = last_iter ? FS_DRAIN : FS_HEAD;
            FS_DRAIN:  if (pops_q == IT_W'(N_ITER)) state_d = FS_FINISH;
            FS_FINISH: if (start) state_d = FS_HEAD;
            default:   state_d = FS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            FS_HEAD:   mem_req = space;
            FS_BODY:   mem_req = 1'b1;
            FS_FINISH: done    = 1'b1;
            default:   ;
        endcase
    end

    // Address and occupancy bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            iter_q    <= '0;
            pops_q    <= '0;
            off_q     <= '0;
            claimed_q <= '0;
        end else begin
            if (launch) begin
                base_q <= base_addr;
                iter_q <= '0;
                off_q  <= '0;
            end else if (accept) begin
                off_q <= last_off ? '0 : off_q + 1'b1;
                if (last_off && !last_iter) begin
                    iter_q <= iter_q + 1'b1;
                end
            end

            if (launch) begin
                pops_q <= '0;
            end else if (pop) begin
                pops_q <= pops_q + 1'b1;
            end

            unique case ({head_take, pop})
                2'b10:   claimed_q <= claimed_q + 1'b1;
                2'b01:   claimed_q <= claimed_q - 1'b1;
                default: claimed_q <= claimed_q;
            endcase
        end
    end

endmodule

// File: rtl/wfb_window_buffer.sv
module wfb_window_buffer
    import wfb_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 16,
    parameter int LANE_DEPTH    = 4,
    parameter int N_ITER        = 100,
    parameter bit HOLD_CONSUMER = 1'b1,
    localparam int CNT_W = $clog2(LANE_DEPTH + 1),
    localparam int WIN_W = WIN_LEN * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              win_valid,
    input  logic              win_ready,
    output logic [WIN_W-1:0]  win_data,
    output logic              win_stall,
    output logic              done
);

    logic                     asm_push;
    logic [WIN_W-1:0]         asm_window;
    logic [WIN_W-1:0]         heads;
    logic [WIN_LEN-1:0]       lane_empty;
    logic [WIN_LEN-1:0]       lane_full;
    logic [WIN_LEN*CNT_W-1:0] lane_lvl_flat;
    logic                     avail;
    logic                     pop;

    assign avail     = ~|lane_empty;
    assign pop       = avail & win_ready;
    assign win_valid = avail;

    wfb_fetch #(
        .ADDR_W (ADDR_W),
        .DEPTH  (LANE_DEPTH),
        .N_ITER (N_ITER)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base_addr (base_addr),
        .mem_ready (mem_ready),
        .pop       (pop),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .done      (done)
    );

    wfb_assemble #(
        .DATA_W (DATA_W)
    ) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rvalid (mem_rvalid),
        .rdata  (mem_rdata),
        .push   (asm_push),
        .window (asm_window)
    );

    for (genvar k = 0; k < WIN_LEN; k++) begin : g_lane
        wfb_lane #(
            .DATA_W (DATA_W),
            .DEPTH  (LANE_DEPTH)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (asm_push),
            .wdata (asm_window[k*DATA_W +: DATA_W]),
            .pop   (pop),
            .rdata (heads[k*DATA_W +: DATA_W]),
            .empty (lane_empty[k]),
            .full  (lane_full[k]),
            .level (lane_lvl_flat[k*CNT_W +: CNT_W])
        );
    end

    if (HOLD_CONSUMER) begin : g_hold
        logic [WIN_W-1:0] last_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                last_q <= '0;
            end else if (pop) begin
                last_q <= heads;
            end
        end
        assign win_data  = avail ? heads : last_q;
        assign win_stall = ~avail;
    end else begin : g_bubble
        assign win_data  = avail ? heads : '0;
        assign win_stall = 1'b0;
    end

endmodule

// File: rtl/wfb_window_buffer_chk.sv
module wfb_window_buffer_chk #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 16,
    parameter int WIN_LEN = 3,
    parameter int CNT_W   = 3,
    parameter bit HOLD    = 1'b1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mem_req,
    input logic                     mem_ready,
    input logic [ADDR_W-1:0]        mem_addr,
    input logic                     win_valid,
    input logic [WIN_LEN*DATA_W-1:0] win_data,
    input logic                     done,
    input logic                     asm_push,
    input logic [WIN_LEN-1:0]       lane_full,
    input logic [WIN_LEN*CNT_W-1:0] lane_lvl_flat
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !win_valid && !done));

    p_lockstep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lane_lvl_flat == {WIN_LEN{lane_lvl_flat[CNT_W-1:0]}});

    p_valid_filled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (lane_lvl_flat[CNT_W-1:0] != '0));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        asm_push |-> !(|lane_full));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    p_done_drained_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !win_valid);

    if (HOLD) begin : g_hold_chk
        p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!win_valid && $past(!win_valid)) |-> $stable(win_data));
    end else begin : g_bubble_chk
        p_bubble_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !win_valid |-> (win_data == '0));
    end

endmodule

bind wfb_window_buffer wfb_window_buffer_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .WIN_LEN (wfb_pkg::WIN_LEN),
    .CNT_W   (CNT_W),
    .HOLD    (HOLD_CONSUMER)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .mem_ready     (mem_ready),
    .mem_addr      (mem_addr),
    .win_valid     (win_valid),
    .win_data      (win_data),
    .done          (done),
    .asm_push      (asm_push),
    .lane_full     (lane_full),
    .lane_lvl_flat (lane_lvl_flat)
);

// File: tb/wfb_window_buffer_test.sv
module wfb_mem_model #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          req,
    input  logic          ready,
    input  logic [AW-1:0] addr,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);
    logic          s1_v = 1'b0;
    logic [AW-1:0] s1_a = '0;

    initial rvalid = 1'b0;
    initial rdata  = '0;

    always @(posedge clk) begin
        s1_v   <= req & ready;
        s1_a   <= addr;
        rvalid <= s1_v;
        rdata  <= {16'h0, s1_a} * 32'h0001_0003 + 32'h0000_0077;
    end
endmodule

module wfb_window_buffer_test;
    localparam int DW    = 32;
    localparam int AW    = 16;
    localparam int DEPTH = 4;
    localparam int NIT   = 100;
    localparam int WW    = 3 * DW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          mem_ready = 1'b1;
    logic          win_ready = 1'b1;

    logic          mem_req, mem_req_b;
    logic [AW-1:0] mem_addr, mem_addr_b;
    logic          rvalid, rvalid_b;
    logic [DW-1:0] rdata, rdata_b;
    logic          win_valid, win_valid_b;
    logic [WW-1:0] win_data, win_data_b;
    logic          win_stall, win_stall_b;
    logic          done, done_b;

    wfb_window_buffer #(.DATA_W(DW), .ADDR_W(AW), .LANE_DEPTH(DEPTH), .N_ITER(NIT),
                        .HOLD_CONSUMER(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rvalid(rvalid), .mem_rdata(rdata),
        .win_valid(win_valid), .win_ready(win_ready), .win_data(win_data),
        .win_stall(win_stall), .done(done));

    wfb_window_buffer #(.DATA_W(DW), .ADDR_W(AW), .LANE_DEPTH(DEPTH), .N_ITER(NIT),
                        .HOLD_CONSUMER(1'b0)) uut_bub (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .mem_req(mem_req_b), .mem_addr(mem_addr_b), .mem_ready(mem_ready),
        .mem_rvalid(rvalid_b), .mem_rdata(rdata_b),
        .win_valid(win_valid_b), .win_ready(win_ready), .win_data(win_data_b),
        .win_stall(win_stall_b), .done(done_b));

    wfb_mem_model #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .req(mem_req), .ready(mem_ready), .addr(mem_addr),
        .rvalid(rvalid), .rdata(rdata));
    wfb_mem_model #(.AW(AW), .DW(DW)) u_mem_b (
        .clk(clk), .req(mem_req_b), .ready(mem_ready), .addr(mem_addr_b),
        .rvalid(rvalid_b), .rdata(rdata_b));

    int errors = 0;
    int checks = 0;
    int accesses = 0;
    int pops = 0;
    logic [WW-1:0] exp_q [$];
    logic [AW-1:0] addr_q [$];
    logic [WW-1:0] last_win = '0;
    logic          mon_on = 1'b0;
    logic          throttle = 1'b0;
    logic [15:0]   lfsr = 16'hACE1;
    logic          prev_wait = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic          finished = 1'b0;

    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        return {16'h0, a} * 32'h0001_0003 + 32'h0000_0077;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [WW-1:0] act, input logic [WW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Driver: start a run, then load the scoreboard with its windows and addresses.
    task automatic launch(input logic [AW-1:0] base);
        @(posedge clk); #1;
        base_addr = base;
        start     = 1'b1;
        @(posedge clk); #1;
        start    = 1'b0;
        accesses = 0;
        pops     = 0;
        for (int i = 0; i < NIT; i++) begin
            exp_q.push_back({word_at(base + AW'(i + 2)), word_at(base + AW'(i + 1)),
                             word_at(base + AW'(i))});
            for (int k = 0; k < 3; k++) addr_q.push_back(base + AW'(i + k));
        end
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 6000) begin
            @(negedge clk);
            n++;
        end
        check(done, req, "done after run", WW'(done), WW'(1));
    endtask

    // Pseudo-random throttling of memory and consumer
    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (throttle) begin
            mem_ready = lfsr[0] | lfsr[3];
            win_ready = lfsr[5] | lfsr[1];
        end
    end

    // Monitor
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (prev_wait) begin
                check(mem_req && mem_addr == prev_addr, "R11", "held request",
                      WW'(mem_addr), WW'(prev_addr));
            end
            prev_wait = mem_req && !mem_ready;
            prev_addr = mem_addr;

            if (mem_req && mem_ready) begin
                accesses++;
                if (addr_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected request", WW'(mem_addr), '0);
                end else begin
                    logic [AW-1:0] ea;
                    ea = addr_q.pop_front();
                    check(mem_addr == ea, "R3", "request address", WW'(mem_addr), WW'(ea));
                end
                check((accesses + 2) / 3 - pops <= DEPTH, "R5", "windows claimed",
                      WW'((accesses + 2) / 3 - pops), WW'(DEPTH));
            end

            check(win_valid_b == win_valid, "R7", "valid matches hold mode",
                  WW'(win_valid_b), WW'(win_valid));

            if (win_valid && win_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected window", win_data, '0);
                end else begin
                    logic [WW-1:0] ew;
                    ew = exp_q.pop_front();
                    check(win_data == ew, "R2", "window content", win_data, ew);
                end
                check(win_data_b == win_data, "R7", "bubble-mode window", win_data_b, win_data);
                last_win = win_data;
                pops++;
            end else if (!win_valid) begin
                check(win_stall && win_data == last_win, "R6", "held window on stall",
                      win_data, last_win);
                check(!win_stall_b && win_data_b == '0, "R7", "bubble output",
                      win_data_b, '0);
            end

            if (done && exp_q.size() != 0) begin
                check(1'b0, "R8", "done before last window", WW'(exp_q.size()), '0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "WDOG", "run did not finish", '0, WW'(1));
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req, "R1", "mem_req after reset", WW'(mem_req), '0);
        check(!win_valid, "R1", "win_valid after reset", WW'(win_valid), '0);
        check(!done, "R1", "done after reset", WW'(done), '0);
        mon_on = 1'b1;

        // Run 1: free-flowing memory and consumer
        launch(16'd0);
        wait_done("R8");
        check(accesses == 3 * NIT, "R4", "access count", WW'(accesses), WW'(3 * NIT));
        check(exp_q.size() == 0, "R2", "all windows delivered", WW'(exp_q.size()), '0);
        check(!win_valid, "R10", "no window after run", WW'(win_valid), '0);
        repeat (3) @(negedge clk);
        check(done, "R8", "done stays high", WW'(done), WW'(1));

        // Run 2: consumer blocked, then throttled both ways
        win_ready = 1'b0;
        launch(16'd500);
        repeat (40) @(negedge clk);
        check(!mem_req, "R5", "requests stop when full", WW'(mem_req), '0);
        check(accesses == 3 * DEPTH, "R5", "accesses with consumer blocked",
              WW'(accesses), WW'(3 * DEPTH));
        throttle = 1'b1;
        repeat (60) @(negedge clk);
        check(!done, "R9", "run still busy before stray start", WW'(done), '0);
        @(posedge clk); #1;
        base_addr = 16'd9000;
        start     = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_done("R9");
        check(accesses == 3 * NIT, "R4", "access count throttled", WW'(accesses), WW'(3 * NIT));
        check(exp_q.size() == 0, "R9", "stray start left windows unchanged",
              WW'(exp_q.size()), '0);
        check(!win_valid, "R10", "no window after run 2", WW'(win_valid), '0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule